// File: doc/BRIEF.md
# Two-Channel Dimming Mode Controller

This block produces two 8-bit brightness words, one per LED channel, for the dimming modulators that follow it. Three push keys drive it. One key picks the operating mode and the other two belong to the two channels. The block does all of its work on a periodic tick strobe, which a free-running timer supplies once per rollover. Its timing is therefore set by the tick rate and does not depend on the system clock.

Every key passes through a filter. The filter turns a press that has been held long enough into a single event. Three modes are available. In Test mode both words sit at fixed levels. In Fade mode both words sweep up and down by one count on each tick. In Manual mode a press of a channel key raises that channel by a coarse step. After reset the controller starts in Fade mode with both channels climbing. Channel A starts at half scale and channel B at zero, so the two channels have a staggered soft start.

Top module: `dim_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to Fade mode (`mode_code` = 1), `level_a` = 0x80 and `level_b` = 0x00, with both channels set to count upward.
- R2: In Fade mode each tick changes each level by exactly one count in that channel's current direction. After reset this makes both levels rise tick by tick.
- R3: On clock edges where `tick` is low, `mode_code`, `level_a` and `level_b` keep their values, whatever the keys are doing.
- R4: A key press is accepted only on the third consecutive tick that samples the key high. A high run of one or two ticks has no effect.
- R5: A key that stays held produces exactly one event. The key must be sampled low on some tick before it can produce another event.
- R6: Mode key events cycle the mode through Test (0), Fade (1), Manual (2) and back to Test. On the tick that carries a mode event, the levels are updated according to the mode in force before that tick.
- R7: In Fade mode a level that has reached 255 turns around and becomes 254 on the next tick. A level that has reached 0 becomes 1 on the next tick.
- R8: In Manual mode a channel key event adds 0x10 to that channel's level. The sum saturates at 255.
- R9: In Test mode every tick loads `level_a` with 0xC0 and `level_b` with 0x40.
- R10: Channel key events are ignored in Test and Fade modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle strobe that paces all filtering and level updates |
| key_a | input | 1 | Channel A key, high when pressed, already synchronised |
| key_b | input | 1 | Channel B key, high when pressed, already synchronised |
| key_mode | input | 1 | Mode key, high when pressed, already synchronised |
| level_a | output | 8 | Brightness word for channel A |
| level_b | output | 8 | Brightness word for channel B |
| mode_code | output | 2 | Current mode: 0 Test, 1 Fade, 2 Manual |

## Verification
The bound checker verifies on every clock the properties that hold tick by tick:
- outputs stay frozen between ticks;
- Fade ticks move each level by exactly one count;
- Manual ticks never lower a level;
- Test ticks load the fixed levels;
- every mode change follows the legal cycle.

Properties that depend on history can only be shown by the bench's scenarios:
- the three-tick acceptance rule, including short glitches that must be rejected;
- the single event for a held key;
- which mode acts on the tick that carries a mode event;
- turnaround at both ends of the range;
- saturation after repeated Manual presses.

// File: rtl/dimctl_pkg.sv
// Shared types and default constants for the dimming mode controller.
// Assumes an 8-bit level unless a user overrides the widths at the top.
package dimctl_pkg;

    typedef enum logic [1:0] {
        MODE_TEST   = 2'd0,
        MODE_FADE   = 2'd1,
        MODE_MANUAL = 2'd2
    } dim_mode_e;

    localparam int          DEF_LVL_W        = 8;
    localparam int          DEF_STEP         = 16;
    localparam int          DEF_STABLE_TICKS = 3;
    localparam int unsigned DEF_RESET_A      = 8'h80;
    localparam int unsigned DEF_RESET_B      = 8'h00;
    localparam int unsigned DEF_TEST_A       = 8'hC0;
    localparam int unsigned DEF_TEST_B       = 8'h40;

endpackage

// File: rtl/press_filter.sv
// Key filter: counts the consecutive ticks on which the raw key is high and
// raises a one-cycle press event, coincident with the tick, on the tick that
// completes the required run. The counter saturates, so a held key fires once.
// Assumes raw is already synchronised to clk.
module press_filter #(
    parameter int STABLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(STABLE_TICKS + 1);
    localparam logic [CW-1:0] RUN_FIRE = CW'(STABLE_TICKS - 1);
    localparam logic [CW-1:0] RUN_SAT  = CW'(STABLE_TICKS);
    localparam logic [CW-1:0] RUN_ONE  = CW'(1);

    logic [CW-1:0] run_q;

    // Event when this tick extends the high run to the required length.
    always_comb press = tick && raw && (run_q == RUN_FIRE);

    // Track the length of the current high run, cleared by a low sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (tick) begin
            if (!raw)
                run_q <= '0;
            else if (run_q != RUN_SAT)
                run_q <= run_q + RUN_ONE;
        end
    end
endmodule

// File: rtl/mode_seq.sv
// Mode sequencer: advances Test -> Fade -> Manual -> Test on each mode key
// event. Leaves reset in Fade so that the soft-start ramp runs at once.
// Assumes adv only pulses on a tick cycle.
module mode_seq
    import dimctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    output dim_mode_e mode
);
    dim_mode_e mode_q, mode_d;

    // Next mode in the cycle.
    always_comb begin
        mode_d = mode_q;
        if (adv) begin
            case (mode_q)
                MODE_TEST:   mode_d = MODE_FADE;
                MODE_FADE:   mode_d = MODE_MANUAL;
                default:     mode_d = MODE_TEST;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_FADE;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/chan_level.sv
// One channel's level: a fixed load in Test mode, a bouncing one-count ramp
// in Fade mode, and a saturating coarse step per press in Manual mode.
// Acts only on tick cycles. The mode input is the mode before this tick.
module chan_level
    import dimctl_pkg::*;
#(
    parameter int          LVL_W     = 8,
    parameter int          STEP      = 16,
    parameter int unsigned RESET_LVL = 0,
    parameter int unsigned TEST_LVL  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  dim_mode_e        mode,
    input  logic             press,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] LVL_MAX  = '1;
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
    localparam logic [LVL_W-1:0] STEP_V   = LVL_W'(STEP);
    localparam logic [LVL_W-1:0] HEADROOM = LVL_MAX - STEP_V;
    localparam logic [LVL_W-1:0] RST_V    = LVL_W'(RESET_LVL);
    localparam logic [LVL_W-1:0] TEST_V   = LVL_W'(TEST_LVL);

    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             up_q, up_d;

    // Next level and direction for the current tick.
    always_comb begin
        lvl_d = lvl_q;
        up_d  = up_q;
        if (tick) begin
            case (mode)
                MODE_TEST: lvl_d = TEST_V;
                MODE_FADE: begin
                    if (up_q) begin
                        if (lvl_q == LVL_MAX) begin
                            up_d  = 1'b0;
                            lvl_d = lvl_q - LVL_ONE;
                        end else
                            lvl_d = lvl_q + LVL_ONE;
                    end else begin
                        if (lvl_q == '0) begin
                            up_d  = 1'b1;
                            lvl_d = lvl_q + LVL_ONE;
                        end else
                            lvl_d = lvl_q - LVL_ONE;
                    end
                end
                MODE_MANUAL: begin
                    if (press)
                        lvl_d = (lvl_q > HEADROOM) ? LVL_MAX : lvl_q + STEP_V;
                end
                default: lvl_d = lvl_q;
            endcase
        end
    end

    // Level and ramp direction registers; the ramp starts upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= RST_V;
            up_q  <= 1'b1;
        end else begin
            lvl_q <= lvl_d;
            up_q  <= up_d;
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/dim_mode_ctrl.sv
// Top of the two-channel dimming mode controller. Filters the three keys,
// sequences the mode and holds one level engine per channel.
// Assumes the keys are synchronised and tick is a single-cycle strobe.
module dim_mode_ctrl
    import dimctl_pkg::*;
#(
    parameter int          LVL_W        = DEF_LVL_W,
    parameter int          STEP         = DEF_STEP,
    parameter int          STABLE_TICKS = DEF_STABLE_TICKS,
    parameter int unsigned RESET_A      = DEF_RESET_A,
    parameter int unsigned RESET_B      = DEF_RESET_B,
    parameter int unsigned TEST_A       = DEF_TEST_A,
    parameter int unsigned TEST_B       = DEF_TEST_B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             key_a,
    input  logic             key_b,
    input  logic             key_mode,
    output logic [LVL_W-1:0] level_a,
    output logic [LVL_W-1:0] level_b,
    output logic [1:0]       mode_code
);
    localparam int N_CH = 2;

    logic [N_CH-1:0]  ch_raw;
    logic [N_CH-1:0]  ch_press;
    logic [LVL_W-1:0] ch_level [N_CH];
    logic             mode_press;
    dim_mode_e        mode;

    assign ch_raw = {key_b, key_a};

    press_filter #(.STABLE_TICKS(STABLE_TICKS)) u_mode_key (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(key_mode), .press(mode_press)
    );

    mode_seq u_mode (
        .clk(clk), .rst_n(rst_n), .adv(mode_press), .mode(mode)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        press_filter #(.STABLE_TICKS(STABLE_TICKS)) u_key (
            .clk(clk), .rst_n(rst_n), .tick(tick), .raw(ch_raw[g]), .press(ch_press[g])
        );
        chan_level #(
            .LVL_W    (LVL_W),
            .STEP     (STEP),
            .RESET_LVL((g == 0) ? RESET_A : RESET_B),
            .TEST_LVL ((g == 0) ? TEST_A : TEST_B)
        ) u_lvl (
            .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
            .press(ch_press[g]), .level(ch_level[g])
        );
    end

    assign level_a   = ch_level[0];
    assign level_b   = ch_level[1];
    assign mode_code = mode;
endmodule

// File: rtl/dimctl_checker.sv
// Checker for dim_mode_ctrl: cycle-level properties on the top's ports.
// Assumes the package default test levels and an 8-bit level.
module dimctl_checker
    import dimctl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [7:0] level_a,
    input logic [7:0] level_b,
    input logic [1:0] mode_code
);
    localparam logic [7:0] TA = 8'(DEF_TEST_A);
    localparam logic [7:0] TB = 8'(DEF_TEST_B);

    // R3: nothing moves without a tick
    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(level_a) && $stable(level_b) && $stable(mode_code)));

    // R2: a Fade tick moves each level by exactly one count
    assert_fade_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_code == 2'd1) |=>
        ((level_a == $past(level_a) + 8'd1) || (level_a == $past(level_a) - 8'd1)) &&
        ((level_b == $past(level_b) + 8'd1) || (level_b == $past(level_b) - 8'd1)));

    // R8: a Manual tick never lowers a level
    assert_manual_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_code == 2'd2) |=>
        (level_a >= $past(level_a)) && (level_b >= $past(level_b)));

    // R9: a Test tick loads the fixed levels
    assert_test_levels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_code == 2'd0) |=> (level_a == TA) && (level_b == TB));

    // R6: the mode code stays legal and follows the cycle
    assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code != 2'd3);
    assert_mode_from_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'd0) |=> (mode_code == 2'd0 || mode_code == 2'd1));
    assert_mode_from_fade_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'd1) |=> (mode_code == 2'd1 || mode_code == 2'd2));
    assert_mode_from_manual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'd2) |=> (mode_code == 2'd2 || mode_code == 2'd0));
endmodule

bind dim_mode_ctrl dimctl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .level_a(level_a), .level_b(level_b), .mode_code(mode_code)
);

// File: tb/sim_dim_mode_ctrl.sv
// Bench for dim_mode_ctrl: a table walk from reset, then directed tests.
module sim_dim_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       key_a = 1'b0, key_b = 1'b0, key_mode = 1'b0;
    logic [7:0] level_a, level_b;
    logic [1:0] mode_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dim_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .key_a(key_a), .key_b(key_b), .key_mode(key_mode),
        .level_a(level_a), .level_b(level_b), .mode_code(mode_code)
    );

    // Row: {keys a,b,mode ; expected mode ; expected level_a ; expected level_b}
    localparam int NV = 31;
    localparam logic [20:0] VEC [NV] = '{
        {3'b000, 2'd1, 8'h81, 8'h01},  // R2 soft start
        {3'b000, 2'd1, 8'h82, 8'h02},  // R2
        {3'b001, 2'd1, 8'h83, 8'h03},  // R4 run 1
        {3'b001, 2'd1, 8'h84, 8'h04},  // R4 run 2
        {3'b001, 2'd2, 8'h85, 8'h05},  // R6 fires, old mode acts
        {3'b001, 2'd2, 8'h85, 8'h05},  // R5 held
        {3'b100, 2'd2, 8'h85, 8'h05},
        {3'b100, 2'd2, 8'h85, 8'h05},
        {3'b100, 2'd2, 8'h95, 8'h05},  // R8 step
        {3'b100, 2'd2, 8'h95, 8'h05},  // R5 held
        {3'b010, 2'd2, 8'h95, 8'h05},
        {3'b010, 2'd2, 8'h95, 8'h05},
        {3'b010, 2'd2, 8'h95, 8'h15},  // R8
        {3'b100, 2'd2, 8'h95, 8'h15},  // R4 glitches
        {3'b000, 2'd2, 8'h95, 8'h15},
        {3'b100, 2'd2, 8'h95, 8'h15},
        {3'b100, 2'd2, 8'h95, 8'h15},
        {3'b000, 2'd2, 8'h95, 8'h15},
        {3'b001, 2'd2, 8'h95, 8'h15},
        {3'b001, 2'd2, 8'h95, 8'h15},
        {3'b001, 2'd0, 8'h95, 8'h15},  // R6 to Test
        {3'b000, 2'd0, 8'hC0, 8'h40},  // R9
        {3'b100, 2'd0, 8'hC0, 8'h40},  // R10
        {3'b100, 2'd0, 8'hC0, 8'h40},
        {3'b100, 2'd0, 8'hC0, 8'h40},
        {3'b001, 2'd0, 8'hC0, 8'h40},
        {3'b001, 2'd0, 8'hC0, 8'h40},
        {3'b001, 2'd1, 8'hC0, 8'h40},  // R6 to Fade
        {3'b100, 2'd1, 8'hC1, 8'h41},  // R10
        {3'b100, 2'd1, 8'hC2, 8'h42},
        {3'b100, 2'd1, 8'hC3, 8'h43}
    };
    localparam string VTAG [NV] = '{
        "R2", "R2", "R4", "R4", "R6", "R5", "R4", "R4", "R8", "R5",
        "R4", "R4", "R8", "R4", "R4", "R4", "R4", "R4", "R4", "R4",
        "R6", "R9", "R10", "R10", "R10", "R9", "R9", "R6", "R10", "R10",
        "R10"
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            summary();
        end
    end

    task automatic check(input string tag, input logic [1:0] em,
                         input logic [7:0] ea, input logic [7:0] eb);
        checks++;
        if (mode_code !== em || level_a !== ea || level_b !== eb) begin
            errors++;
            $display("FAIL %s: actual mode=%0d a=%h b=%h, expected mode=%0d a=%h b=%h",
                     tag, mode_code, level_a, level_b, em, ea, eb);
        end
    endtask

    // One tick with the given key levels; outputs settle by the next negedge.
    task automatic do_tick(input logic a, input logic b, input logic m);
        @(negedge clk);
        key_a = a; key_b = b; key_mode = m; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", 2'd1, 8'h80, 8'h00);

        // R3: keys busy, no tick
        key_a = 1'b1; key_b = 1'b1; key_mode = 1'b1;
        repeat (6) @(negedge clk);
        check("R3", 2'd1, 8'h80, 8'h00);
        key_a = 1'b0; key_b = 1'b0; key_mode = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_tick(VEC[i][20], VEC[i][19], VEC[i][18]);
            check(VTAG[i], VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R7: climb to the top and turn around
        for (int i = 0; i < 60; i++) do_tick(1'b0, 1'b0, 1'b0);
        check("R7", 2'd1, 8'hFF, 8'h7F);
        do_tick(1'b0, 1'b0, 1'b0);
        check("R7", 2'd1, 8'hFE, 8'h80);
        // R7: descend to zero and turn around
        for (int i = 0; i < 254; i++) do_tick(1'b0, 1'b0, 1'b0);
        check("R7", 2'd1, 8'h00, 8'h80);
        do_tick(1'b0, 1'b0, 1'b0);
        check("R7", 2'd1, 8'h01, 8'h7F);

        // R6: into Manual while still fading
        for (int i = 0; i < 3; i++) do_tick(1'b0, 1'b0, 1'b1);
        check("R6", 2'd2, 8'h04, 8'h7C);
        do_tick(1'b0, 1'b0, 1'b0);
        check("R3", 2'd2, 8'h04, 8'h7C);

        // R8: repeated steps and saturation
        for (int p = 1; p <= 17; p++) begin
            for (int t = 0; t < 3; t++) do_tick(1'b1, 1'b0, 1'b0);
            do_tick(1'b0, 1'b0, 1'b0);
            if (p == 15) check("R8", 2'd2, 8'hF4, 8'h7C);
            if (p == 16) check("R8", 2'd2, 8'hFF, 8'h7C);
            if (p == 17) check("R8", 2'd2, 8'hFF, 8'h7C);
        end

        // R1: reset from a running state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 2'd1, 8'h80, 8'h00);
        rst_n = 1'b1;
        do_tick(1'b0, 1'b0, 1'b0);
        check("R2", 2'd1, 8'h81, 8'h01);

        summary();
    end
endmodule